// File: doc/BRIEF.md
# Guarded Extended-Configuration Latch

This block holds a small set of extended configuration fields that sit in the upper bits of four neighbouring control registers: interrupt enable, interrupt status, FIFO control and modem control. A single guard bit decides whether these fields are live. While the guard is set, software writes the fields through per-field strobes, and the outputs carry the programmed values to the logic that uses them. Clearing the guard copies the fields into a private shadow store and drives every live field to zero. Older software that knows nothing of the extended fields therefore sees them as zero and cannot change them.

Setting the guard again copies the shadow store back into the live fields. The normal sequence is to set the guard, program the fields, then clear the guard to lock the settings away. The guard bit and the field data arrive on a shared write-data bus, which carries only its upper bits (7 down to 4). The decode that forms the strobes lives outside this block.

Top module: `xreg_guard`

## Requirements
- R1: After reset the guard output `xen_o` is 0, all live field outputs are 0 and the shadow store holds zeros.
- R2: A cycle with `xen_wr` high loads the guard from `wr_data[4]`, and the new guard value is visible on `xen_o` after that clock edge. Without `xen_wr` the guard keeps its value.
- R3: While the guard is 1, each strobe in `fld_wr` loads its field on the next edge. Bit 0 loads the 4-bit interrupt-enable field from `wr_data[7:4]`. Bit 1 loads the 2-bit interrupt-status field from `wr_data[5:4]`. Bit 2 loads the 2-bit FIFO-control field from `wr_data[5:4]`. Bit 3 loads the 3-bit modem-control field from `wr_data[7:5]`. Fields whose strobe is low keep their values.
- R4: While the guard is 0, all live fields read 0 and field strobes have no effect on the live fields or on the shadow store.
- R5: A guard write of 0 while the guard is 1 zeroes every live field on the next edge and saves their values into the shadow store.
- R6: A guard write of 1 while the guard is 0 makes the live fields equal to the shadow store on the next edge. No intermediate value is visible.
- R7: A guard write that repeats the current value changes nothing. Writing 1 while the guard is 1 does not restore the shadow store. Writing 0 while it is 0 does not overwrite the shadow store.
- R8: A field strobe in the same cycle as a guard write of 0 (guard at 1) saves the newly written value. A field strobe in the same cycle as a guard write of 1 (guard at 0) is ignored.
- R9: The first guard set after reset restores all-zero fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xen_wr | input | 1 | Strobe that writes the guard bit |
| fld_wr | input | 4 | Per-field write strobes (0 IER, 1 ISR, 2 FCR, 3 MCR) |
| wr_data | input | 4 | Write data bits 7..4 of the register bus |
| xen_o | output | 1 | Current guard value |
| ier_o | output | 4 | Live interrupt-enable extension field |
| isr_o | output | 2 | Live interrupt-status extension field |
| fcr_o | output | 2 | Live FIFO-control extension field |
| mcr_o | output | 3 | Live modem-control extension field |

## Verification
The bench aims at the guard transitions that a gated write-enable would get wrong.

- **Repeated guard writes:** the bench rewrites 1 after the fields have changed. A design that restores on every write of 1 would bring back stale values. It also rewrites 0 while locked, which would wipe the shadow store in a design that saves on every write of 0.
- **Writes while locked:** the bench writes every field with ones while the guard is 0, then re-enables. A leaky design would show those values or keep them.
- **Same-cycle writes:** the bench pairs a field write with each guard transition. The value written at lock time must survive, and the value written at unlock time must be dropped.
- **Reset in mid-run:** the bench resets after the shadow store holds data. A design that leaves the shadow store uncleared would restore the old settings.

// File: rtl/xreg_guard_pkg.sv
package xreg_guard_pkg;
  localparam int NUM_FLD = 4;
  localparam int BUS_MSB = 7;
  localparam int BUS_LSB = 4;
  localparam int GUARD_BIT = 4;

  function automatic int fld_w(input int idx);
    case (idx)
      0: return 4;
      1: return 2;
      2: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int fld_lsb(input int idx);
    case (idx)
      3: return 5;
      default: return 4;
    endcase
  endfunction

  function automatic int fld_off(input int idx);
    int acc;
    acc = 0;
    for (int k = 0; k < idx; k++) acc += fld_w(k);
    return acc;
  endfunction

  localparam int TOTAL_W = fld_off(NUM_FLD);
endpackage

// File: rtl/xreg_rst_sync.sv
module xreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/xreg_guard_ctl.sv
module xreg_guard_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic xen_wr,
  input  logic xen_din,
  output logic en_o,
  output logic save_o,
  output logic restore_o
);
  logic en_q, en_d, en_ce;

  always_comb begin
    en_ce     = xen_wr;
    en_d      = xen_din;
    save_o    = xen_wr & ~xen_din & en_q;
    restore_o = xen_wr &  xen_din & ~en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_ce) en_q <= en_d;
  end

  assign en_o = en_q;

  // R2: guard follows the written bit
  a_r2_guard_load: assert property (@(posedge clk) disable iff (!rst_n)
    xen_wr |=> en_q == $past(xen_din));
  // R2 / R7: guard holds without a write
  a_r2_guard_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !xen_wr |=> $stable(en_q));
endmodule

// File: rtl/xreg_field_slice.sv
module xreg_field_slice #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         save_i,
  input  logic         restore_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] live_o
);
  logic [W-1:0] live_q, live_d, shadow_q, shadow_d, merged;
  logic         live_ce, shadow_ce, wr_ok;

  always_comb begin
    wr_ok     = wr_i & en_i;
    merged    = wr_ok ? wdata_i : live_q;
    live_ce   = save_i | restore_i | wr_ok;
    shadow_ce = save_i;
    shadow_d  = merged;
    if (save_i)         live_d = '0;
    else if (restore_i) live_d = shadow_q;
    else                live_d = merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= '0;
      shadow_q <= '0;
    end else begin
      if (live_ce)   live_q   <= live_d;
      if (shadow_ce) shadow_q <= shadow_d;
    end
  end

  assign live_o = live_q;

  // R4: locked fields read zero
  a_r4_locked_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> live_q == '0);
  // R4 / R7: shadow only moves on a save
  a_r4_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !save_i |=> $stable(shadow_q));
  // R5: save keeps the live value
  a_r5_save_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i && !wr_i) |=> (shadow_q == $past(live_q)) && (live_q == '0));
  // R8: same-cycle write is the value saved
  a_r8_save_write: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i && wr_i) |=> shadow_q == $past(wdata_i));
  // R6: restore brings back the shadow
  a_r6_restore: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> live_q == $past(shadow_q));
endmodule

// File: rtl/xreg_guard.sv
module xreg_guard
  import xreg_guard_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   xen_wr,
  input  logic [NUM_FLD-1:0]     fld_wr,
  input  logic [BUS_MSB:BUS_LSB] wr_data,
  output logic                   xen_o,
  output logic [3:0]             ier_o,
  output logic [1:0]             isr_o,
  output logic [1:0]             fcr_o,
  output logic [2:0]             mcr_o
);
  logic               rst_s_n;
  logic               en, save, restore;
  logic [TOTAL_W-1:0] live_all;

  xreg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s_n)
  );

  xreg_guard_ctl u_ctl (
    .clk(clk), .rst_n(rst_s_n), .xen_wr(xen_wr), .xen_din(wr_data[GUARD_BIT]),
    .en_o(en), .save_o(save), .restore_o(restore)
  );

  for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
    localparam int FW  = fld_w(g);
    localparam int FL  = fld_lsb(g);
    localparam int FO  = fld_off(g);
    xreg_field_slice #(.W(FW)) u_slice (
      .clk(clk), .rst_n(rst_s_n), .en_i(en), .save_i(save),
      .restore_i(restore), .wr_i(fld_wr[g]), .wdata_i(wr_data[FL+:FW]),
      .live_o(live_all[FO+:FW])
    );
  end

  assign xen_o = en;
  assign ier_o = live_all[fld_off(0)+:4];
  assign isr_o = live_all[fld_off(1)+:2];
  assign fcr_o = live_all[fld_off(2)+:2];
  assign mcr_o = live_all[fld_off(3)+:3];

  // R3: accepted write lands on the output
  a_r3_ier_load: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fld_wr[0] && xen_o && !xen_wr) |=> ier_o == $past(wr_data[7:4]));
  // R3: no strobe, no change while enabled
  a_r3_mcr_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!fld_wr[3] && !xen_wr) |=> $stable(mcr_o));
endmodule

// File: tb/xreg_guard_tb_top.sv
module xreg_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xen_wr = 1'b0;
  logic [3:0] fld_wr = '0;
  logic [7:4] wr_data = '0;
  logic       xen_o;
  logic [3:0] ier_o;
  logic [1:0] isr_o, fcr_o;
  logic [2:0] mcr_o;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  xreg_guard dut_i (
    .clk(clk), .rst_n(rst_n), .xen_wr(xen_wr), .fld_wr(fld_wr),
    .wr_data(wr_data), .xen_o(xen_o), .ier_o(ier_o), .isr_o(isr_o),
    .fcr_o(fcr_o), .mcr_o(mcr_o)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic chk_all(input string req, input int e, input int ie, input int is,
                         input int fc, input int mc);
    chk({req, " guard"}, xen_o, e);
    chk({req, " ier"}, ier_o, ie);
    chk({req, " isr"}, isr_o, is);
    chk({req, " fcr"}, fcr_o, fc);
    chk({req, " mcr"}, mcr_o, mc);
  endtask

  task automatic bus(input logic g, input logic [3:0] f, input logic [7:4] d);
    @(negedge clk);
    xen_wr = g; fld_wr = f; wr_data = d;
    @(negedge clk);
    xen_wr = 1'b0; fld_wr = '0; wr_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk_all("R1", 0, 0, 0, 0, 0);
  endtask

  task automatic t_first_enable();
    bus(1'b1, 4'b0000, 4'h1);
    chk_all("R9/R2", 1, 0, 0, 0, 0);
  endtask

  task automatic t_program();
    bus(1'b0, 4'b0001, 4'hA);
    chk_all("R3 ier", 1, 4'hA, 0, 0, 0);
    bus(1'b0, 4'b0010, 4'h3);
    chk_all("R3 isr", 1, 4'hA, 3, 0, 0);
    bus(1'b0, 4'b0100, 4'h2);
    chk_all("R3 fcr", 1, 4'hA, 3, 2, 0);
    bus(1'b0, 4'b1000, 4'hE);
    chk_all("R3 mcr", 1, 4'hA, 3, 2, 7);
    bus(1'b0, 4'b0101, 4'h5);
    chk_all("R3 multi", 1, 5, 3, 1, 7);
  endtask

  task automatic t_lock_and_ignore();
    bus(1'b1, 4'b0000, 4'h0);
    chk_all("R5 lock", 0, 0, 0, 0, 0);
    bus(1'b0, 4'b1111, 4'hF);
    chk_all("R4 ignored", 0, 0, 0, 0, 0);
    bus(1'b1, 4'b0000, 4'h0);
    chk_all("R7 rewrite0", 0, 0, 0, 0, 0);
    bus(1'b1, 4'b0000, 4'h1);
    chk_all("R6 restore", 1, 5, 3, 1, 7);
  endtask

  task automatic t_repeat_set();
    bus(1'b0, 4'b0001, 4'h3);
    bus(1'b1, 4'b0000, 4'h1);
    chk_all("R7 rewrite1", 1, 3, 3, 1, 7);
  endtask

  task automatic t_same_cycle();
    bus(1'b1, 4'b0001, 4'h6);
    chk_all("R8 lock+write", 0, 0, 0, 0, 0);
    bus(1'b1, 4'b0001, 4'h9);
    chk_all("R8 unlock+write", 1, 6, 3, 1, 7);
  endtask

  task automatic t_reset_clears_shadow();
    bus(1'b1, 4'b0000, 4'h0);
    do_reset();
    chk_all("R1 rereset", 0, 0, 0, 0, 0);
    bus(1'b1, 4'b0000, 4'h1);
    chk_all("R9 zero restore", 1, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_first_enable();
    t_program();
    t_lock_and_ignore();
    t_repeat_set();
    t_same_cycle();
    t_reset_clears_shadow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule